// File: doc/BRIEF.md
# Protected Configuration Byte Store

This block holds the configuration contents of a programmable device as two byte-wide regions: a functional configuration array and a 64-bit user signature. A single command port carries read, write, erase and secure operations. Read responses come back one clock after the command, together with a valid flag and an error flag.

A one-way security bit guards the configuration array. Once it is set, the array can no longer be read and neither region can be written. The only way to clear the bit is a bulk erase, which wipes both regions. A programming cycle therefore starts with an erase. The signature is readable at all times, so it can carry identification codes or revision numbers.

A 16-bit checksum covers every stored byte of both regions, the signature included. It is always available on its own output.

Top module: `sigstore_top`

## Requirements
- R1: The signature is 8 bytes, selected by `cmd_addr[2:0]` when `cmd_region` is 1. `sig_word` shows signature byte k on bits [8k+7:8k], so byte 7 sits at the most significant end.
- R2: Commands use `cmd_op` encoding 00 read, 01 write, 10 erase and 11 secure. `cmd_region` is 0 for the array and 1 for the signature. A read raises `rd_valid` in the following cycle, with the addressed byte on `rd_data`. In cycles with no read response, `rd_data` is zero.
- R3: A signature read never raises `rd_err` and returns the stored byte, whatever the security state.
- R4: An array read issued while `secured` is high returns zero with `rd_err` high, in that response cycle only.
- R5: A secure command sets `secured` from the next cycle. Only an erase clears it again.
- R6: While `secured` is high, writes to either region leave every stored byte and the checksum unchanged.
- R7: An erase sets every byte of both regions to zero and clears `secured`, effective from the next cycle.
- R8: `csum` equals the sum modulo 65536 of all array bytes and all signature bytes. It reflects a write from the cycle after that write.
- R9: `csum` is zero after reset and in the cycle after an erase.
- R10: After reset, all stored bytes are zero, `secured` is low, and `rd_valid` and `rd_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 read, 01 write, 10 erase, 11 secure |
| cmd_region | input | 1 | 0 configuration array, 1 signature |
| cmd_addr | input | ADDR_W (5) | Byte address inside the region |
| cmd_wdata | input | BYTE_W (8) | Write data |
| rd_valid | output | 1 | Read response present |
| rd_data | output | BYTE_W (8) | Read response byte |
| rd_err | output | 1 | Read refused by security |
| secured | output | 1 | Security bit |
| csum | output | CSUM_W (16) | Running checksum of all bytes |
| sig_word | output | SIG_BYTES*BYTE_W (64) | Whole signature, byte 7 most significant |

## Verification
Some properties are checked by assertions on every cycle:
- a security bit that only falls after an erase;
- refused reads that carry zero data;
- signature reads that are never refused;
- a checksum that returns to zero after erase;
- a signature and checksum that stay unchanged across writes while secured.

Other properties need the bench's scenarios, because they depend on the stored contents and on a model holding the same bytes:
- the correct byte landing at each address;
- the byte order of the signature word;
- the exact checksum value after a series of writes;
- a fresh programming pass after an erase.

// File: rtl/sigstore_pkg.sv
package sigstore_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_WRITE  = 2'b01,
    OP_ERASE  = 2'b10,
    OP_SECURE = 2'b11
  } op_e;

  localparam logic REGION_ARRAY = 1'b0;
  localparam logic REGION_SIG   = 1'b1;
endpackage

// File: rtl/sigstore_bank.sv
module sigstore_bank #(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [BYTE_W-1:0]         wdata,
  output logic [DEPTH*BYTE_W-1:0]   contents
);
  // one register per byte so a bulk erase completes in a single cycle
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [BYTE_W-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (rst || clr)
        cell_q <= '0;
      else if (we && (waddr == AW'(g)))
        cell_q <= wdata;
    end
    assign contents[g*BYTE_W +: BYTE_W] = cell_q;
  end
endmodule

// File: rtl/sigstore_guard.sv
module sigstore_guard
  import sigstore_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       secured_q,
  output logic       do_erase,
  output logic       do_write,
  output logic       do_read
);
  op_e op;
  assign op = op_e'(cmd_op);

  assign do_erase = cmd_valid && (op == OP_ERASE);
  assign do_read  = cmd_valid && (op == OP_READ);
  assign do_write = cmd_valid && (op == OP_WRITE) && !secured_q;

  always_ff @(posedge clk) begin
    if (rst)
      secured_q <= 1'b0;
    else if (do_erase)
      secured_q <= 1'b0;
    else if (cmd_valid && (op == OP_SECURE))
      secured_q <= 1'b1;
  end

  // R5: security only drops after an erase command
  assert_sec_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (secured_q && !(cmd_valid && cmd_op == OP_ERASE)) |=> secured_q);

  // R5: a secure command takes effect in the next cycle
  assert_sec_set_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_SECURE) |=> secured_q);

  // R7: erase leaves the device unsecured
  assert_erase_unsec_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_ERASE) |=> !secured_q);
endmodule

// File: rtl/sigstore_csum.sv
module sigstore_csum #(
  parameter int BYTE_W = 8,
  parameter int CSUM_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              upd,
  input  logic [BYTE_W-1:0] old_byte,
  input  logic [BYTE_W-1:0] new_byte,
  output logic [CSUM_W-1:0] csum_q
);
  logic [CSUM_W-1:0] delta;
  assign delta = CSUM_W'(new_byte) - CSUM_W'(old_byte);

  // incremental update: remove the replaced byte, add the new one
  always_ff @(posedge clk) begin
    if (rst || clr)
      csum_q <= '0;
    else if (upd)
      csum_q <= csum_q + delta;
  end

  // R9: checksum is zero after an erase
  assert_erase_zero_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (csum_q == '0));

  // R6: with no accepted write and no erase the checksum holds
  assert_csum_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!upd && !clr) |=> $stable(csum_q));
endmodule

// File: rtl/sigstore_top.sv
module sigstore_top
  import sigstore_pkg::*;
#(
  parameter int ARRAY_BYTES = 32,
  parameter int SIG_BYTES   = 8,
  parameter int BYTE_W      = 8,
  parameter int CSUM_W      = 16,
  localparam int ARR_AW     = $clog2(ARRAY_BYTES),
  localparam int SIG_AW     = $clog2(SIG_BYTES),
  localparam int ADDR_W     = (ARR_AW > SIG_AW) ? ARR_AW : SIG_AW
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  input  logic [1:0]                  cmd_op,
  input  logic                        cmd_region,
  input  logic [ADDR_W-1:0]           cmd_addr,
  input  logic [BYTE_W-1:0]           cmd_wdata,
  output logic                        rd_valid,
  output logic [BYTE_W-1:0]           rd_data,
  output logic                        rd_err,
  output logic                        secured,
  output logic [CSUM_W-1:0]           csum,
  output logic [SIG_BYTES*BYTE_W-1:0] sig_word
);
  logic do_erase, do_write, do_read, secured_q;
  logic [ARRAY_BYTES*BYTE_W-1:0] arr_flat;
  logic [SIG_BYTES*BYTE_W-1:0]   sig_flat;
  logic [ARR_AW-1:0] arr_idx;
  logic [SIG_AW-1:0] sig_idx;
  logic [BYTE_W-1:0] cur_byte;
  logic deny;

  assign arr_idx = cmd_addr[ARR_AW-1:0];
  assign sig_idx = cmd_addr[SIG_AW-1:0];

  sigstore_guard u_guard (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .secured_q (secured_q),
    .do_erase  (do_erase),
    .do_write  (do_write),
    .do_read   (do_read)
  );

  sigstore_bank #(.DEPTH(ARRAY_BYTES), .BYTE_W(BYTE_W)) u_arr (
    .clk      (clk),
    .rst      (rst),
    .clr      (do_erase),
    .we       (do_write && (cmd_region == REGION_ARRAY)),
    .waddr    (arr_idx),
    .wdata    (cmd_wdata),
    .contents (arr_flat)
  );

  sigstore_bank #(.DEPTH(SIG_BYTES), .BYTE_W(BYTE_W)) u_sig (
    .clk      (clk),
    .rst      (rst),
    .clr      (do_erase),
    .we       (do_write && (cmd_region == REGION_SIG)),
    .waddr    (sig_idx),
    .wdata    (cmd_wdata),
    .contents (sig_flat)
  );

  // byte currently held at the addressed location (read data and old value)
  assign cur_byte = (cmd_region == REGION_SIG) ? sig_flat[sig_idx*BYTE_W +: BYTE_W]
                                               : arr_flat[arr_idx*BYTE_W +: BYTE_W];

  sigstore_csum #(.BYTE_W(BYTE_W), .CSUM_W(CSUM_W)) u_csum (
    .clk      (clk),
    .rst      (rst),
    .clr      (do_erase),
    .upd      (do_write),
    .old_byte (cur_byte),
    .new_byte (cmd_wdata),
    .csum_q   (csum)
  );

  assign deny = do_read && (cmd_region == REGION_ARRAY) && secured_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= do_read;
      rd_err   <= deny;
      rd_data  <= (do_read && !deny) ? cur_byte : '0;
    end
  end

  assign secured  = secured_q;
  assign sig_word = sig_flat;

  // R4: a refused read carries zero data inside a response
  assert_deny_zero_R4: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> (rd_valid && rd_data == '0));

  // R4: array read while secured is refused
  assert_deny_when_sec_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_READ && cmd_region == REGION_ARRAY && secured) |=> rd_err);

  // R3: signature reads are never refused
  assert_sig_open_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_READ && cmd_region == REGION_SIG) |=> !rd_err);

  // R6: signature contents unchanged by writes while secured
  assert_sec_nowrite_R6: assert property (@(posedge clk) disable iff (rst)
    (secured && cmd_valid && cmd_op == OP_WRITE) |=> ($stable(sig_word) && $stable(csum)));

  // R2: no response without a read
  assert_resp_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_op == OP_READ) |=> (!rd_valid && rd_data == '0));
endmodule

// File: tb/sigstore_top_tb_top.sv
module sigstore_top_tb_top;
  localparam int NA = 32;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic cmd_region = 1'b0;
  logic [4:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic rd_valid, rd_err, secured;
  logic [7:0] rd_data;
  logic [15:0] csum;
  logic [63:0] sig_word;

  always #10 clk = ~clk;

  sigstore_top dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_region(cmd_region), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
    .secured(secured), .csum(csum), .sig_word(sig_word)
  );

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  int ref_arr[NA];
  int ref_sig[NS];
  bit ref_sec;
  bit exp_rv, exp_err;
  int exp_rd;

  function automatic int ref_csum();
    int s = 0;
    for (int i = 0; i < NA; i++) s += ref_arr[i];
    for (int i = 0; i < NS; i++) s += ref_sig[i];
    return s % 65536;
  endfunction

  function automatic logic [63:0] ref_word();
    logic [63:0] w = '0;
    for (int i = 0; i < NS; i++) w[i*8 +: 8] = ref_sig[i][7:0];
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(rd_valid == exp_rv, tag, "rd_valid", rd_valid, exp_rv);
    check(rd_err == exp_err, tag, "rd_err", rd_err, exp_err);
    check(rd_data == exp_rd[7:0], tag, "rd_data", rd_data, exp_rd);
    check(secured == ref_sec, tag, "secured", secured, ref_sec);
    check(csum == ref_csum(), tag, "csum", csum, ref_csum());
    check(sig_word == ref_word(), tag, "sig_word", sig_word, ref_word());
  endtask

  // one command per clock; model advanced at the edge, outputs sampled at negedge
  task automatic cmd(input bit v, input int op, input bit reg_s, input int addr,
                     input int data, input string tag);
    cmd_valid = v; cmd_op = op[1:0]; cmd_region = reg_s;
    cmd_addr = addr[4:0]; cmd_wdata = data[7:0];
    @(posedge clk);
    exp_rv = v && op == 0;
    exp_err = exp_rv && !reg_s && ref_sec;
    exp_rd = (exp_rv && !exp_err) ? (reg_s ? ref_sig[addr % NS] : ref_arr[addr % NA]) : 0;
    if (v && op == 1 && !ref_sec) begin
      if (reg_s) ref_sig[addr % NS] = data & 255;
      else ref_arr[addr % NA] = data & 255;
    end else if (v && op == 2) begin
      for (int i = 0; i < NA; i++) ref_arr[i] = 0;
      for (int i = 0; i < NS; i++) ref_sig[i] = 0;
      ref_sec = 0;
    end else if (v && op == 3) begin
      ref_sec = 1;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin : watchdog
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < NA; i++) ref_arr[i] = 0;
    for (int i = 0; i < NS; i++) ref_sig[i] = 0;
    ref_sec = 0; exp_rv = 0; exp_err = 0; exp_rd = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    compare_all("R10 reset state R9");
    cmd(0, 0, 0, 0, 0, "R10 idle after reset");

    // program array and signature (R8 checksum tracks each write)
    for (int i = 0; i < NA; i++) cmd(1, 1, 0, i, (i * 37 + 11) & 255, "R8 array write");
    for (int i = 0; i < NS; i++) cmd(1, 1, 1, i, 8'hA0 + i * 3, "R8 R1 signature write");
    cmd(1, 1, 0, 5, 8'hFF, "R8 overwrite replaces byte");
    for (int i = 0; i < NA; i++) cmd(1, 0, 0, i, 0, "R2 array readback");
    for (int i = 0; i < NS; i++) cmd(1, 0, 1, i, 0, "R1 signature readback");
    cmd(0, 0, 0, 0, 0, "R2 no response when idle");

    // secure the device
    cmd(1, 3, 0, 0, 0, "R5 secure");
    cmd(1, 0, 0, 3, 0, "R4 array read refused");
    cmd(0, 0, 0, 0, 0, "R4 error lasts one cycle");
    cmd(1, 0, 1, 7, 0, "R3 signature read while secured");
    cmd(1, 1, 1, 7, 8'h00, "R6 signature write ignored");
    cmd(1, 1, 0, 3, 8'h12, "R6 array write ignored");
    cmd(1, 0, 1, 7, 0, "R6 R3 signature unchanged");
    cmd(1, 3, 0, 0, 0, "R5 secure again stays set");
    for (int i = 0; i < 4; i++) cmd(1, 0, 0, i * 9, 0, "R4 repeated refusal");

    // erase and reprogram
    cmd(1, 2, 0, 0, 0, "R7 R9 erase");
    for (int i = 0; i < NA; i += 5) cmd(1, 0, 0, i, 0, "R7 array cleared");
    for (int i = 0; i < NS; i++) cmd(1, 0, 1, i, 0, "R7 signature cleared");
    for (int i = 0; i < NA; i++) cmd(1, 1, 0, i, 255, "R8 full array 0xFF");
    for (int i = 0; i < NS; i++) cmd(1, 1, 1, i, (i << 4) | (7 - i), "R1 byte order pattern");
    cmd(1, 0, 0, 31, 0, "R2 last array byte");
    cmd(1, 3, 0, 0, 0, "R5 secure after reprogram");
    cmd(1, 0, 0, 31, 0, "R4 refused after reprogram");
    cmd(1, 2, 0, 0, 0, "R7 erase clears security");
    cmd(1, 0, 0, 31, 0, "R7 array readable after erase");
    cmd(1, 1, 1, 2, 8'h5C, "R8 write after erase accepted");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule